// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Unit

This unit watches a set of already-synchronised pin levels, grouped into banks of equal width. Each pin has a 2-bit trigger selector that arms it for rising edges, falling edges, both, or nothing. A qualifying edge latches into that bank's status register. Software clears status bits by writing 1s to them.

Each bank has a mask register. One word address sets mask bits and a second word address clears them; either address reads back the current mask. A bank's interrupt line is high whenever an unmasked status bit is set. Level-sensitive triggering is not provided.

A small word-addressed access port carries the status and mask traffic. Reads return data one clock after the request.

Top module: `edge_irq_unit`

## Requirements
- R1: Pin p takes its trigger code from trig_cfg_i[2p+1:2p]. Code 0 detects nothing, 1 detects rising edges, 2 detects falling edges and 3 detects both.
- R2: A qualifying change between two consecutive clock samples of pin_lvl_i sets that pin's status bit at the second sampling edge. The first sample after reset only serves as the reference level and never produces an edge.
- R3: Bank b's status sits at word address 0x80 + 4*b. A write there clears every status bit whose data bit is 1; zero data bits leave their status bits unchanged.
- R4: If a new edge and a write-1-clear reach the same status bit in the same cycle, the bit ends up set.
- R5: Writing to 0xA0 + 4*b sets every mask bit of bank b whose data bit is 1. A read of that address returns the mask.
- R6: Writing to 0xC0 + 4*b clears every mask bit of bank b whose data bit is 1. A read of that address also returns the mask.
- R7: irq_o[b] is high exactly when bank b has a status bit that is set and unmasked. It follows the registers with no added delay, and one bank's line does not depend on any other bank.
- R8: A status bit still latches while its pin is masked. Unmasking the pin later raises the interrupt.
- R9: After reset, all mask bits are 1, all status bits are 0, every irq_o bit is 0 and acc_rdata_o is 0.
- R10: acc_rdata_o holds the read result in the cycle after the read request and is 0 otherwise. Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | NUM_BANKS*BANK_W | Synchronised pin levels |
| trig_cfg_i | input | 2*NUM_BANKS*BANK_W | Per-pin trigger codes, 2 bits each |
| acc_en_i | input | 1 | Access request |
| acc_we_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | ADDR_W | Byte address, word aligned |
| acc_wdata_i | input | BANK_W | Write data |
| acc_rdata_o | output | BANK_W | Registered read data |
| irq_o | output | NUM_BANKS | Interrupt line per bank |

## Verification
A pin change or a register write that is driven before clock edge k shows up in status, mask and irq_o right after edge k. A read request driven before edge k produces its data right after edge k. The bench drives all stimulus on the falling clock edge. For each read it pushes the expected word into a queue, and a monitor pops and compares that word at the falling edge after the capturing rising edge. Interrupt lines are compared at a falling edge once the triggering write or pin change has been clocked in. The edge-versus-clear collision is staged in a single cycle so that both hit the same rising edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  // address region, acc_addr_i[7:5]
  localparam logic [2:0] RGN_STS  = 3'b100;
  localparam logic [2:0] RGN_MSET = 3'b101;
  localparam logic [2:0] RGN_MCLR = 3'b110;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;
endpackage

// File: rtl/eint_edge_det.sv
module eint_edge_det
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   lvl_i,
  input  logic [2*NUM_PINS-1:0] cfg_i,
  output logic [NUM_PINS-1:0]   edge_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic                armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_e mode;
    logic  rise, fall;
    assign mode = trig_e'(cfg_i[2*p +: 2]);
    assign rise = lvl_i[p] & ~prev_q[p];
    assign fall = ~lvl_i[p] & prev_q[p];
    always_comb begin
      unique case (mode)
        TRIG_RISE: edge_o[p] = armed_q & rise;
        TRIG_FALL: edge_o[p] = armed_q & fall;
        TRIG_BOTH: edge_o[p] = armed_q & (rise | fall);
        default:   edge_o[p] = 1'b0;
      endcase
    end
  end

  // first sample after reset is reference only
  p_unarmed_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (edge_o == '0));
endmodule

// File: rtl/eint_bank.sv
module eint_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] edge_i,
  input  logic [BANK_W-1:0] sts_clr_i,
  input  logic [BANK_W-1:0] msk_set_i,
  input  logic [BANK_W-1:0] msk_clr_i,
  output logic [BANK_W-1:0] sts_o,
  output logic [BANK_W-1:0] msk_o,
  output logic              irq_o
);
  logic [BANK_W-1:0] sts_q, msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      sts_q <= (sts_q & ~sts_clr_i) | edge_i;  // edge wins over clear
      msk_q <= (msk_q | msk_set_i) & ~msk_clr_i;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = |(sts_q & ~msk_q);

  p_edge_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != '0) |=> ((sts_q & $past(edge_i)) == $past(edge_i)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_clr_i & ~edge_i) != '0) |=> ((sts_q & $past(sts_clr_i & ~edge_i)) == '0));
  p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_set_i != '0) |=> ((msk_q & $past(msk_set_i)) == $past(msk_set_i)));
  p_mask_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_clr_i != '0) |=> ((msk_q & $past(msk_clr_i)) == '0));
  p_all_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk_q) |-> !irq_o);
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0]     pin_lvl_i,
  input  logic [2*NUM_BANKS*BANK_W-1:0]   trig_cfg_i,
  input  logic                            acc_en_i,
  input  logic                            acc_we_i,
  input  logic [ADDR_W-1:0]               acc_addr_i,
  input  logic [BANK_W-1:0]               acc_wdata_i,
  output logic [BANK_W-1:0]               acc_rdata_o,
  output logic [NUM_BANKS-1:0]            irq_o
);
  localparam int NUM_PINS = NUM_BANKS * BANK_W;
  localparam int RGN_W    = ADDR_W - 5;  // NUM_BANKS <= 8, ADDR_W >= 8

  logic [NUM_PINS-1:0] edge_w;
  logic [RGN_W-1:0]    rgn;
  logic [2:0]          bank_idx;
  logic                aligned, is_sts, is_mset, is_mclr;
  logic [BANK_W-1:0]   sts_w [NUM_BANKS];
  logic [BANK_W-1:0]   msk_w [NUM_BANKS];
  logic [BANK_W-1:0]   rd_mux;
  logic [BANK_W-1:0]   rdata_q;

  assign rgn      = acc_addr_i[ADDR_W-1:5];
  assign bank_idx = acc_addr_i[4:2];
  assign aligned  = (acc_addr_i[1:0] == 2'b00);
  assign is_sts   = aligned && (rgn == RGN_W'(RGN_STS));
  assign is_mset  = aligned && (rgn == RGN_W'(RGN_MSET));
  assign is_mclr  = aligned && (rgn == RGN_W'(RGN_MCLR));

  eint_edge_det #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pin_lvl_i),
    .cfg_i  (trig_cfg_i),
    .edge_o (edge_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              sel;
    logic [BANK_W-1:0] clr_v, set_v, unm_v;
    assign sel   = acc_en_i && acc_we_i && (bank_idx == 3'(b));
    assign clr_v = (sel && is_sts)  ? acc_wdata_i : '0;
    assign set_v = (sel && is_mset) ? acc_wdata_i : '0;
    assign unm_v = (sel && is_mclr) ? acc_wdata_i : '0;

    eint_bank #(.BANK_W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .edge_i    (edge_w[b*BANK_W +: BANK_W]),
      .sts_clr_i (clr_v),
      .msk_set_i (set_v),
      .msk_clr_i (unm_v),
      .sts_o     (sts_w[b]),
      .msk_o     (msk_w[b]),
      .irq_o     (irq_o[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == 3'(b)) begin
        if (is_sts)                rd_mux = sts_w[b];
        else if (is_mset || is_mclr) rd_mux = msk_w[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdata_q <= '0;
    else if (acc_en_i && !acc_we_i)  rdata_q <= rd_mux;
    else                             rdata_q <= '0;
  end

  assign acc_rdata_o = rdata_q;

  p_rdata_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && !acc_we_i) |=> (acc_rdata_o == '0));
  p_unmapped_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !acc_we_i && !is_sts && !is_mset && !is_mclr) |=> (acc_rdata_o == '0));
endmodule

// File: tb/edge_irq_unit_bench.sv
module edge_irq_unit_bench;
  localparam int NB = 2;
  localparam int BW = 32;
  localparam int NP = NB * BW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pin_lvl = '0;
  logic [2*NP-1:0] trig_cfg = '0;
  logic            acc_en = 1'b0, acc_we = 1'b0;
  logic [7:0]      acc_addr = '0;
  logic [BW-1:0]   acc_wdata = '0;
  logic [BW-1:0]   acc_rdata;
  logic [NB-1:0]   irq;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [BW-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic  rd_d = 1'b0;

  always #5 clk = ~clk;

  edge_irq_unit #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(8)) u_edge_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(pin_lvl), .trig_cfg_i(trig_cfg),
    .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata), .irq_o(irq)
  );

  always @(posedge clk) rd_d <= rst_n && acc_en && !acc_we;

  // monitor: rdata due the cycle after the request
  always @(negedge clk) begin
    if (rd_d) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (acc_rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, acc_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [BW-1:0] e, input string tag);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = a;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    acc_en = 0;
  endtask

  task automatic chk_irq(input logic [NB-1:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
    end
  endtask

  task automatic pins(input logic [3:0] v);
    @(negedge clk);
    pin_lvl[3:0] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1 codes: pin0 rise, pin1 fall, pin2 both, pin3 off, pin37 rise
    trig_cfg[1:0] = 2'd1; trig_cfg[3:2] = 2'd2;
    trig_cfg[5:4] = 2'd3; trig_cfg[7:6] = 2'd0;
    trig_cfg[2*37 +: 2] = 2'd1;
    pin_lvl[0] = 1'b1;  // high through reset: must not count as an edge (R2)
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== '0 || acc_rdata !== '0) begin
      fails++;
      $display("FAIL R9: irq=%b rdata=%h expected=0 0", irq, acc_rdata);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_irq(2'b00, "R9 irq after reset");
    rd(8'h80, 32'h0, "R9/R2 status after reset");
    rd(8'hA0, 32'hFFFF_FFFF, "R9 mask after reset");
    rd(8'hC0, 32'hFFFF_FFFF, "R6 mask readback via clear addr");

    pins(4'b0000);  // fall on a rise-only pin
    rd(8'h80, 32'h0, "R1 falling edge on rise pin ignored");

    pins(4'b1111);
    rd(8'h80, 32'h5, "R1 rise detection per code");
    chk_irq(2'b00, "R8 latched while masked");

    wr(8'hC0, 32'h1);
    chk_irq(2'b01, "R6/R8 unmask raises irq");

    pins(4'b0000);
    rd(8'h80, 32'h7, "R1 fall detection per code");

    wr(8'h80, 32'h1);
    chk_irq(2'b00, "R3/R7 cleared unmasked bit drops irq");
    rd(8'h80, 32'h6, "R3 write-1 clear");
    wr(8'h80, 32'h0);
    rd(8'h80, 32'h6, "R3 zero data no effect");

    wr(8'hC0, 32'h2);
    chk_irq(2'b01, "R7 unmasked pending bit");
    wr(8'hA0, 32'h2);
    chk_irq(2'b00, "R5 mask set silences irq");
    rd(8'hA0, 32'hFFFF_FFFE, "R5 mask readback");

    // R4: edge and clear of bit 0 in the same cycle
    @(negedge clk);
    pin_lvl[0] = 1'b1;
    acc_en = 1; acc_we = 1; acc_addr = 8'h80; acc_wdata = 32'h1;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
    rd(8'h80, 32'h7, "R4 edge wins over clear");
    chk_irq(2'b01, "R4 irq still raised");
    wr(8'h80, 32'h7);
    rd(8'h80, 32'h0, "R3 clear all");

    @(negedge clk);
    pin_lvl[37] = 1'b1;
    rd(8'h84, 32'h20, "R2 bank1 status");
    chk_irq(2'b00, "R7 bank1 masked");
    wr(8'hC4, 32'h20);
    chk_irq(2'b10, "R7 per-bank line");
    rd(8'hA4, 32'hFFFF_FFDF, "R6 bank1 mask");

    rd(8'h10, 32'h0, "R10 unmapped read");
    rd(8'h81, 32'h0, "R10 misaligned read");
    wr(8'hE4, 32'hFFFF_FFFF);
    wr(8'hA5, 32'hFFFF_FFFF);
    rd(8'hA4, 32'hFFFF_FFDF, "R10 unmapped write ignored");
    chk_irq(2'b10, "R10 irq unchanged");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule